// File: doc/BRIEF.md
# Test-Data Capture Shifter with Signature LFSR

This block sits on the return path of a serial test master and takes in the captured test data one bit at a time. Two 32-bit shift registers run side by side. The first register compresses the data-in stream into a signature. It uses a linear-feedback shift register whose polynomial is picked by a 3-bit code, and it starts from a programmed seed. When the vector is finished, its final value is latched into a result register. The second register collects raw bits, and every completed 32-bit word is handed to a word-write port for storage.

A vector is framed by a one-cycle start pulse and a one-cycle end pulse. Between them, each qualified shift-enable pulse moves one bit into both registers. The raw register normally takes the data-in line. In loopback mode it takes the mode-select line or the data-out line instead, chosen by a select input. The signature register always takes data-in. At the end of a vector, any bits left in a partial raw word are flushed to the word port together with their count. The seed and the polynomial code are expected to be stable before a vector starts.

Top module: `capture_sig_shifter`

## Requirements
- R1: After reset, `sig_result`, `sig_valid`, `word_data`, `word_bits` and `word_valid` are all zero, and the raw bit count is zero.
- R2: A `vec_start` pulse loads the signature register with `seed & M`, where M is the mask of the selected polynomial (all ones for a reserved code). The same pulse clears the raw register and its bit count. In that cycle, `vec_start` overrides `shift_en` and `vec_end`.
- R3: On a shift, the signature register S becomes `({S[30:0], fb ^ data_in}) & M`, where fb is the XOR of S over a tap mask T. The codes are: 0 selects degree 32 (T=0x80200003, M=0xFFFFFFFF); 1 selects degree 24 (T=0x00E10000, M=0x00FFFFFF); 2 selects degree 16 (T=0x0000D008, M=0x0000FFFF); 3 selects degree 8 (T=0x000000B8, M=0x000000FF); 4 selects degree 4 (T=0x0000000C, M=0x0000000F).
- R4: With a polynomial code of 5, 6 or 7, the signature register holds its value on a shift.
- R5: A `vec_end` pulse copies the signature value into `sig_result`, including any shift made in that same cycle. `sig_valid` is high for exactly the one following clock.
- R6: The raw register takes its bit from `data_in` when `loop_mode`=0. When `loop_mode`=1 it takes `msel_in` if `loop_sel`=0 and `dout_in` if `loop_sel`=1. The signature register always takes `data_in`.
- R7: Each raw shift moves the register left and puts the new bit into bit 0. On the 32nd bit of a word, `word_valid` pulses for one clock with the full word (the first bit in bit 31) and `word_bits`=32, and the count restarts at 0.
- R8: When `vec_end` leaves a nonzero partial count, that partial word is output right-aligned, with the earliest bit highest, and `word_bits` gives the count. When the count is zero, no word is produced.
- R9: While `shift_en` is low, the serial inputs have no effect on either register or on the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vec_start | input | 1 | Start-of-vector pulse |
| vec_end | input | 1 | End-of-vector pulse |
| shift_en | input | 1 | Qualified shift-in enable |
| loop_mode | input | 1 | 0: raw source is data-in; 1: loopback |
| loop_sel | input | 1 | Loopback source: 0 mode-select, 1 data-out |
| data_in | input | 1 | Captured test data line |
| msel_in | input | 1 | Mode-select line (loopback source) |
| dout_in | input | 1 | Data-out line (loopback source) |
| poly_code | input | 3 | Polynomial select code |
| seed | input | 32 | Signature seed |
| sig_result | output | 32 | Signature latched at vector end |
| sig_valid | output | 1 | One-cycle strobe with a new signature |
| word_data | output | 32 | Raw word to be written |
| word_bits | output | 6 | Number of valid bits in word_data |
| word_valid | output | 1 | One-cycle word-write strobe |

## Verification
The embedded properties assume that `poly_code` and `seed` are steady around a start pulse, and that the control pulses are ordinary synchronous levels that settle between clock edges. The stimulus changes every input just after a falling edge and holds the setup inputs fixed for the whole of each vector. Same-cycle collisions of start, shift and end are produced only on purpose, to check the stated priority.

// File: rtl/css_pkg.sv
`timescale 1ns/1ps
package css_pkg;
    localparam int SIG_W = 32;

    typedef struct packed {
        logic [SIG_W-1:0] state;
        logic [SIG_W-1:0] result;
        logic             valid;
    } sig_st_t;

    function automatic logic code_ok(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic [SIG_W-1:0] poly_taps(input logic [2:0] code);
        case (code)
            3'd0:    return 32'h8020_0003;
            3'd1:    return 32'h00E1_0000;
            3'd2:    return 32'h0000_D008;
            3'd3:    return 32'h0000_00B8;
            3'd4:    return 32'h0000_000C;
            default: return '0;
        endcase
    endfunction

    function automatic logic [SIG_W-1:0] poly_mask(input logic [2:0] code);
        case (code)
            3'd1:    return 32'h00FF_FFFF;
            3'd2:    return 32'h0000_FFFF;
            3'd3:    return 32'h0000_00FF;
            3'd4:    return 32'h0000_000F;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/css_src_mux.sv
`timescale 1ns/1ps
module css_src_mux (
    input  logic loop_mode,
    input  logic loop_sel,
    input  logic data_in,
    input  logic msel_in,
    input  logic dout_in,
    output logic raw_bit
);
    always_comb begin
        if (!loop_mode)    raw_bit = data_in;
        else if (loop_sel) raw_bit = dout_in;
        else               raw_bit = msel_in;
    end
endmodule

// File: rtl/css_sig_lfsr.sv
`timescale 1ns/1ps
module css_sig_lfsr
    import css_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             end_i,
    input  logic             shift_i,
    input  logic             bit_i,
    input  logic [2:0]       code_i,
    input  logic [SIG_W-1:0] seed_i,
    output logic [SIG_W-1:0] result_o,
    output logic             valid_o
);
    sig_st_t d, q;
    logic [SIG_W-1:0] mask_w, taps_w, nxt;

    always_comb begin
        d      = q;
        d.valid = 1'b0;
        mask_w = poly_mask(code_i);
        taps_w = poly_taps(code_i);
        nxt    = q.state;
        if (start_i) begin
            d.state = seed_i & mask_w;
        end else begin
            if (shift_i && code_ok(code_i))
                nxt = {q.state[SIG_W-2:0], (^(q.state & taps_w)) ^ bit_i} & mask_w;
            d.state = nxt;
            if (end_i) begin
                d.result = nxt;
                d.valid  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign result_o = q.result;
    assign valid_o  = q.valid;

    // R2: start loads the masked seed
    a_r2_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> q.state == ($past(seed_i) & poly_mask($past(code_i))));
    // R4: reserved codes freeze the signature
    a_r4_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !start_i && code_i > 3'd4) |=> $stable(q.state));
    // R5: end strobes the result for one cycle
    a_r5_end_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (end_i && !start_i) |=> (valid_o && result_o == q.state));
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(end_i && !start_i) |=> !valid_o);
endmodule

// File: rtl/css_raw_capture.sv
`timescale 1ns/1ps
module css_raw_capture #(
    parameter int WORD_W = 32,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              end_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o,
    output logic [CNT_W-1:0]  bits_o,
    output logic              valid_o
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  bits;
        logic              valid;
    } raw_st_t;

    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    raw_st_t d, q;
    logic [WORD_W-1:0] sh_n;
    logic [CNT_W-1:0]  cnt_n;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        sh_n    = q.sh;
        cnt_n   = q.cnt;
        if (start_i) begin
            sh_n  = '0;
            cnt_n = '0;
        end else begin
            if (shift_i) begin
                sh_n  = {q.sh[WORD_W-2:0], bit_i};
                cnt_n = q.cnt + 1'b1;
            end
            if (cnt_n == FULL || (end_i && cnt_n != '0)) begin
                d.word  = sh_n;
                d.bits  = cnt_n;
                d.valid = 1'b1;
                sh_n    = '0;
                cnt_n   = '0;
            end
        end
        d.sh  = sh_n;
        d.cnt = cnt_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_o  = q.word;
    assign bits_o  = q.bits;
    assign valid_o = q.valid;

    // R7: count never rests at a full word
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < FULL);
    // R7: the last bit of a word produces a full-word strobe
    a_r7_full_word: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !start_i && q.cnt == FULL - 1'b1) |=> (valid_o && bits_o == FULL));
    // R8: end with nothing pending emits no word
    a_r8_no_empty_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (end_i && !shift_i && q.cnt == '0) |=> !valid_o);
    // R9: idle cycles leave the count alone
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !start_i && !end_i) |=> $stable(q.cnt));
    // R2: start clears the count
    a_r2_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (q.cnt == '0 && !valid_o));
endmodule

// File: rtl/capture_sig_shifter.sv
`timescale 1ns/1ps
module capture_sig_shifter
    import css_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_start,
    input  logic              vec_end,
    input  logic              shift_en,
    input  logic              loop_mode,
    input  logic              loop_sel,
    input  logic              data_in,
    input  logic              msel_in,
    input  logic              dout_in,
    input  logic [2:0]        poly_code,
    input  logic [SIG_W-1:0]  seed,
    output logic [SIG_W-1:0]  sig_result,
    output logic              sig_valid,
    output logic [WORD_W-1:0] word_data,
    output logic [CNT_W-1:0]  word_bits,
    output logic              word_valid
);
    logic raw_bit;

    css_src_mux u_mux (
        .loop_mode (loop_mode),
        .loop_sel  (loop_sel),
        .data_in   (data_in),
        .msel_in   (msel_in),
        .dout_in   (dout_in),
        .raw_bit   (raw_bit)
    );

    css_sig_lfsr u_sig (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (vec_start),
        .end_i    (vec_end),
        .shift_i  (shift_en),
        .bit_i    (data_in),
        .code_i   (poly_code),
        .seed_i   (seed),
        .result_o (sig_result),
        .valid_o  (sig_valid)
    );

    css_raw_capture #(.WORD_W(WORD_W)) u_raw (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (vec_start),
        .end_i   (vec_end),
        .shift_i (shift_en),
        .bit_i   (raw_bit),
        .word_o  (word_data),
        .bits_o  (word_bits),
        .valid_o (word_valid)
    );

    // R6: normal mode puts data_in on the raw path
    a_r6_normal_src: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_mode |-> raw_bit == data_in);
endmodule

// File: tb/capture_sig_shifter_bench.sv
`timescale 1ns/1ps
module capture_sig_shifter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vec_start = 0, vec_end = 0, shift_en = 0;
    logic        loop_mode = 0, loop_sel = 0;
    logic        data_in = 0, msel_in = 0, dout_in = 0;
    logic [2:0]  poly_code = 0;
    logic [31:0] seed = 0;
    logic [31:0] sig_result, word_data;
    logic        sig_valid, word_valid;
    logic [5:0]  word_bits;

    int checks = 0, failures = 0;
    logic [31:0] m_sig, m_sh;
    int          m_cnt;

    always #4 clk = ~clk;

    capture_sig_shifter u_capture_sig_shifter (
        .clk(clk), .rst_n(rst_n), .vec_start(vec_start), .vec_end(vec_end),
        .shift_en(shift_en), .loop_mode(loop_mode), .loop_sel(loop_sel),
        .data_in(data_in), .msel_in(msel_in), .dout_in(dout_in),
        .poly_code(poly_code), .seed(seed), .sig_result(sig_result),
        .sig_valid(sig_valid), .word_data(word_data), .word_bits(word_bits),
        .word_valid(word_valid)
    );

    typedef struct packed {
        logic [2:0]  code;
        logic [31:0] seed;
        logic [6:0]  nbits;
        logic [63:0] data;
        logic        lm;
        logic        ls;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'h0000_0001, 7'd32, 64'hDEAD_BEEF_0000_0000, 1'b0, 1'b0},
        '{3'd1, 32'h00AB_CDEF, 7'd20, 64'hF0F0_3C3C_0000_0000, 1'b0, 1'b0},
        '{3'd2, 32'h0000_ACE1, 7'd40, 64'h1234_5678_9ABC_DEF0, 1'b1, 1'b0},
        '{3'd3, 32'h0000_005A, 7'd64, 64'hCAFE_F00D_55AA_33CC, 1'b1, 1'b1},
        '{3'd4, 32'h0000_0009, 7'd7,  64'hA600_0000_0000_0000, 1'b0, 1'b0},
        '{3'd0, 32'hFFFF_FFFF, 7'd33, 64'h8000_0001_8000_0000, 1'b1, 1'b1},
        '{3'd5, 32'h1234_5678, 7'd10, 64'hFFC0_0000_0000_0000, 1'b0, 1'b0},
        '{3'd3, 32'h0000_0000, 7'd1,  64'h8000_0000_0000_0000, 1'b0, 1'b0}
    };

    function automatic logic [31:0] taps_of(input logic [2:0] c);
        case (c)
            3'd0: return 32'h8020_0003;
            3'd1: return 32'h00E1_0000;
            3'd2: return 32'h0000_D008;
            3'd3: return 32'h0000_00B8;
            3'd4: return 32'h0000_000C;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] mask_of(input logic [2:0] c);
        case (c)
            3'd1: return 32'h00FF_FFFF;
            3'd2: return 32'h0000_FFFF;
            3'd3: return 32'h0000_00FF;
            3'd4: return 32'h0000_000F;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic st, input logic sh, input logic en,
                        input logic di, input logic ms, input logic dq, input string tag);
        logic        exp_wv, exp_sv, src;
        logic [31:0] exp_w, exp_r;
        int          exp_b;
        @(negedge clk);
        vec_start = st; shift_en = sh; vec_end = en;
        data_in = di; msel_in = ms; dout_in = dq;
        exp_wv = 0; exp_sv = 0; exp_w = 0; exp_r = 0; exp_b = 0;
        if (st) begin
            m_sig = seed & mask_of(poly_code);
            m_sh = 0; m_cnt = 0;
        end else begin
            if (sh) begin
                if (poly_code <= 3'd4)
                    m_sig = {m_sig[30:0], (^(m_sig & taps_of(poly_code))) ^ di} & mask_of(poly_code);
                src = !loop_mode ? di : (loop_sel ? dq : ms);
                m_sh = {m_sh[30:0], src};
                m_cnt++;
            end
            if (m_cnt == 32 || (en && m_cnt != 0)) begin
                exp_wv = 1; exp_w = m_sh; exp_b = m_cnt;
                m_sh = 0; m_cnt = 0;
            end
            if (en) begin exp_sv = 1; exp_r = m_sig; end
        end
        @(posedge clk); #1;
        chk(word_valid == exp_wv, {tag, " R7/R8 word_valid"}, 32'(word_valid), 32'(exp_wv));
        if (exp_wv) begin
            chk(word_data == exp_w, {tag, " R6 R7 R8 word_data"}, word_data, exp_w);
            chk(32'(word_bits) == 32'(exp_b), {tag, " R8 word_bits"}, 32'(word_bits), 32'(exp_b));
        end
        chk(sig_valid == exp_sv, {tag, " R5 sig_valid"}, 32'(sig_valid), 32'(exp_sv));
        if (exp_sv)
            chk(sig_result == exp_r, {tag, " R3 R4 R5 sig_result"}, sig_result, exp_r);
    endtask

    initial begin : watchdog
        #1_600_000;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        m_sig = 0; m_sh = 0; m_cnt = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sig_result == 0 && !sig_valid, "R1 sig reset", sig_result, 0);
        chk(word_data == 0 && word_bits == 0 && !word_valid, "R1 word reset", word_data, 0);
        rst_n = 1'b1;

        foreach (VECS[v]) begin
            poly_code = VECS[v].code;
            seed      = VECS[v].seed;
            loop_mode = VECS[v].lm;
            loop_sel  = VECS[v].ls;
            step(1, 0, 0, 0, 0, 0, $sformatf("vec%0d start", v));
            for (int i = 0; i < int'(VECS[v].nbits); i++) begin
                logic b;
                b = VECS[v].data[63 - i];
                step(0, 1, (i == int'(VECS[v].nbits) - 1), b, ~b, b ^ i[0],
                     $sformatf("vec%0d bit%0d", v, i));
            end
            step(0, 0, 0, 0, 0, 0, $sformatf("vec%0d idle", v));
        end

        // R4: reserved code leaves the seed untouched
        poly_code = 3'd7; seed = 32'hA5A5_0F0F; loop_mode = 0;
        step(1, 0, 0, 0, 0, 0, "R4 start");
        for (int i = 0; i < 5; i++) step(0, 1, i == 4, i[0], 0, 0, "R4 shift");
        chk(sig_result == 32'hA5A5_0F0F, "R4 result equals seed", sig_result, 32'hA5A5_0F0F);

        // R9: serial inputs ignored while shift_en is low
        poly_code = 3'd2; seed = 32'h0000_1234;
        step(1, 0, 0, 0, 0, 0, "R9 start");
        step(0, 1, 0, 1, 0, 0, "R9 b0");
        step(0, 1, 0, 0, 0, 0, "R9 b1");
        step(0, 1, 0, 1, 0, 0, "R9 b2");
        for (int i = 0; i < 6; i++) step(0, 0, 0, i[0], ~i[0], i[0], "R9 idle");
        step(0, 0, 1, 1, 1, 1, "R9 end");
        chk(word_bits == 6'd3 && word_data == 32'h5, "R9 three bits kept", word_data, 32'h5);

        // R2: start overrides shift and end in the same cycle
        seed = 32'h0000_BEEF;
        step(0, 1, 0, 1, 0, 0, "R2 pre");
        step(1, 1, 1, 1, 1, 1, "R2 collide");
        chk(!sig_valid && !word_valid, "R2 collision quiet", 32'(sig_valid), 0);
        // R8: end with zero count gives no word
        step(0, 0, 1, 0, 0, 0, "R8 empty end");
        chk(!word_valid && sig_result == 32'h0000_BEEF, "R2 R8 seed only", sig_result, 32'h0000_BEEF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule